// File: doc/BRIEF.md
# DMA Channel Request Handler

This block sits in front of one DMA channel. It collects service requests from the peripheral attached to that channel and turns each one into a single grant request to the channel arbiter. Each grant request carries the number of beats to move. Two kinds of peripheral are supported. A FIFO-type peripheral holds a level request for a single beat while its FIFO is not empty, and a second level request for a block once its FIFO passes a threshold. A trigger-type peripheral sends one-cycle event pulses instead.

Software loads a total beat count for the channel and sets the beats-per-grant value. It can also select a block-only mode in which single-beat requests have no effect. When the arbiter grants the request, the handler counts beats as the data path reports them. When the last beat of the whole transfer completes, the handler sends a one-cycle completion pulse back to the peripheral. Trigger events are queued one deep behind the event in service. Any further event is dropped and recorded in a sticky flag that is cleared by writing one.

Top module: `dma_req_handler`

## Requirements
- R1: `arb_req` rises one clock after the handler is idle with a remaining count above zero and a qualifying request. It stays high, with `arb_len` unchanged, until the cycle in which `arb_grant` is high. It is low in the cycle after that grant.
- R2: When the block request and the single request are both high while the handler is idle, the block request is selected, so `arb_len` is the block length and not 1.
- R3: A single request alone, with block-only mode clear, yields `arb_len` = 1.
- R4: A block or trigger service asks for min(`cfg_arb_size`, remaining count) beats. A `cfg_arb_size` of 0 counts as 1.
- R5: While `cfg_burst_only` = 1, `fifo_single_req` never causes `arb_req`.
- R6: A pending trigger outranks a FIFO block request. Trigger events are counted while the handler is idle or busy. The count holds one event in service plus one pending. A pending event is serviced after the current one finishes.
- R7: An event that arrives while both trigger slots are taken, and in a cycle where no trigger service is finishing, is dropped. It sets `trig_lost`. `trig_lost` stays set until `lost_clr` = 1. If a drop and a clear happen in the same cycle, the set wins.
- R8: `done_pulse` is high for exactly the one clock that follows the `beat_done` that brings the remaining count to zero. While the remaining count is zero, no request is raised.
- R9: `arb_grant` has no effect unless `arb_req` is high. `beat_done` has no effect unless a granted service is in progress.
- R10: After reset, `arb_req`, `done_pulse` and `trig_lost` are 0 and the remaining count is 0.
- R11: `xfer_load` = 1 sets the remaining count to `xfer_count` at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_arb_size | input | ARB_W | Beats per block or trigger grant (0 counts as 1) |
| cfg_burst_only | input | 1 | 1 = single-beat requests are ignored |
| xfer_load | input | 1 | Load the remaining beat count |
| xfer_count | input | CNT_W | Total beats to move for the transfer |
| fifo_single_req | input | 1 | FIFO holds at least one entry (level) |
| fifo_burst_req | input | 1 | FIFO has reached its threshold (level) |
| trig_pulse | input | 1 | One-cycle trigger event |
| lost_clr | input | 1 | Write-one-to-clear for `trig_lost` |
| arb_grant | input | 1 | Arbiter accepts the pending request |
| beat_done | input | 1 | Data path finished one beat |
| arb_req | output | 1 | Request to the channel arbiter |
| arb_len | output | ARB_W | Beats to move for this grant |
| done_pulse | output | 1 | Transfer complete, one clock |
| trig_lost | output | 1 | Sticky flag: a trigger event was dropped |

## Verification
If the remaining count is wrong, the problem shows up at the next block grant: `arb_len` differs from the expected min() value. It also shows up as a missing or early `done_pulse` on the final beat. If the trigger queue count is wrong, the number of trigger services that follow a burst of events is off, or `trig_lost` is set (or stays clear) one clock after the third event. If the state sequencing is wrong, `arb_req` holds past a grant or appears without a qualifying request. Either fault is visible on the first clock after the event.

// File: rtl/dma_rh_pkg.sv
// Shared types for the DMA channel request handler.
// Assumes nothing beyond the enums themselves.
package dma_rh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } rh_state_t;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_SINGLE = 2'd1,
        SRC_BLOCK  = 2'd2,
        SRC_TRIG   = 2'd3
    } rh_src_t;

endpackage

// File: rtl/dma_rh_trig_queue.sv
// Counts trigger events: one in service plus SLOTS-1 pending.
// An event that finds every slot full is dropped and sets a sticky flag.
// Assumes: consume is high for one clock when a trigger service finishes.
module dma_rh_trig_queue #(
    parameter int SLOTS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic consume,
    input  logic lost_clr,
    output logic pending,
    output logic lost
);
    localparam int QW = $clog2(SLOTS + 1);
    localparam logic [QW-1:0] FULL = QW'(SLOTS);

    logic [QW-1:0] cnt;
    logic          drop;
    logic          take;

    // An event is taken if a slot is free or one is freed this cycle.
    always_comb begin
        drop = trig_in && (cnt == FULL) && !consume;
        take = trig_in && !drop;
    end

    // Occupancy count update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt + QW'(take) - QW'(consume);
    end

    // Sticky lost flag; a drop wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lost <= 1'b0;
        else if (drop)
            lost <= 1'b1;
        else if (lost_clr)
            lost <= 1'b0;
    end

    assign pending = (cnt != '0);

endmodule

// File: rtl/dma_rh_counters.sv
// Remaining-transfer and per-grant beat counters, plus the completion pulse.
// Assumes: beat is only high during a granted service, and a service never
// asks for more beats than remain.
module dma_rh_counters #(
    parameter int ARB_W = 4,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             start,
    input  logic [ARB_W-1:0] start_len,
    input  logic             beat,
    output logic [CNT_W-1:0] remaining,
    output logic             last_beat,
    output logic             done
);
    logic [ARB_W-1:0] beats_left;

    // Remaining beats of the whole transfer; a load wins over a beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remaining <= '0;
        else if (load)
            remaining <= load_val;
        else if (beat)
            remaining <= remaining - 1'b1;
    end

    // Beats left in the current grant.
    always_ff @(posedge clk) begin
        if (!rst_n)
            beats_left <= '0;
        else if (start)
            beats_left <= start_len;
        else if (beat)
            beats_left <= beats_left - 1'b1;
    end

    // Completion pulse on the final beat of the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= beat && (remaining == CNT_W'(1));
    end

    assign last_beat = (beats_left == ARB_W'(1));

endmodule

// File: rtl/dma_req_handler.sv
// Request handler for one DMA channel. Selects among trigger, FIFO block and
// FIFO single requests, asks the arbiter for a grant of the right length, and
// tracks beats to completion.
// Assumes: CNT_W > ARB_W; xfer_load is used only while no service is active.
module dma_req_handler
    import dma_rh_pkg::*;
#(
    parameter int ARB_W = 4,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ARB_W-1:0] cfg_arb_size,
    input  logic             cfg_burst_only,
    input  logic             xfer_load,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic             fifo_single_req,
    input  logic             fifo_burst_req,
    input  logic             trig_pulse,
    input  logic             lost_clr,
    input  logic             arb_grant,
    input  logic             beat_done,
    output logic             arb_req,
    output logic [ARB_W-1:0] arb_len,
    output logic             done_pulse,
    output logic             trig_lost
);
    localparam int PADW = CNT_W - ARB_W;

    rh_state_t        state;
    rh_src_t          src_q;
    rh_src_t          sel;
    logic [ARB_W-1:0] len_q;
    logic [ARB_W-1:0] arb_eff;
    logic [ARB_W-1:0] blk_len;
    logic [CNT_W-1:0] remaining;
    logic             trig_pend;
    logic             last_beat;
    logic             beat;
    logic             finish;
    logic             consume;
    logic             start;

    // Pick the request source by priority: trigger, block, then single.
    always_comb begin
        if (trig_pend)
            sel = SRC_TRIG;
        else if (fifo_burst_req)
            sel = SRC_BLOCK;
        else if (fifo_single_req && !cfg_burst_only)
            sel = SRC_SINGLE;
        else
            sel = SRC_NONE;
    end

    // Block length: configured size (0 read as 1) capped by remaining beats.
    always_comb begin
        arb_eff = (cfg_arb_size == '0) ? ARB_W'(1) : cfg_arb_size;
        if (remaining < {{PADW{1'b0}}, arb_eff})
            blk_len = remaining[ARB_W-1:0];
        else
            blk_len = arb_eff;
    end

    // Service-phase strobes.
    always_comb begin
        beat    = (state == ST_XFER) && beat_done;
        finish  = beat && last_beat;
        consume = finish && (src_q == SRC_TRIG);
        start   = (state == ST_REQ) && arb_grant;
    end

    // Idle -> request -> transfer sequencing with source and length capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            src_q <= SRC_NONE;
            len_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if ((remaining != '0) && (sel != SRC_NONE)) begin
                        state <= ST_REQ;
                        src_q <= sel;
                        len_q <= (sel == SRC_SINGLE) ? ARB_W'(1) : blk_len;
                    end
                end
                ST_REQ: begin
                    if (arb_grant)
                        state <= ST_XFER;
                end
                ST_XFER: begin
                    if (finish)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    dma_rh_trig_queue #(
        .SLOTS(2)
    ) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_pulse),
        .consume (consume),
        .lost_clr(lost_clr),
        .pending (trig_pend),
        .lost    (trig_lost)
    );

    dma_rh_counters #(
        .ARB_W(ARB_W),
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (xfer_load),
        .load_val (xfer_count),
        .start    (start),
        .start_len(len_q),
        .beat     (beat),
        .remaining(remaining),
        .last_beat(last_beat),
        .done     (done_pulse)
    );

    assign arb_req = (state == ST_REQ);
    assign arb_len = len_q;

endmodule

// File: rtl/dma_req_handler_sva.sv
// Port-level protocol checks for the request handler, bound to every instance.
module dma_req_handler_sva #(
    parameter int ARB_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ARB_W-1:0] cfg_arb_size,
    input logic             trig_pulse,
    input logic             lost_clr,
    input logic             arb_grant,
    input logic             arb_req,
    input logic [ARB_W-1:0] arb_len,
    input logic             done_pulse,
    input logic             trig_lost
);
    // R1: request and length hold until granted
    p_hold_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arb_req && !arb_grant |=> arb_req && $stable(arb_len));

    // R1: request drops after the grant
    p_drop_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arb_req && arb_grant |=> !arb_req);

    // R4: a request never asks for zero beats
    p_len_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arb_req |-> arb_len != '0);

    // R4: length bounded by the configured size (0 read as 1)
    p_len_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arb_req |-> (arb_len == ARB_W'(1)) || (arb_len <= cfg_arb_size));

    // R7: the lost flag is sticky until cleared
    p_lost_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_lost && !lost_clr |=> trig_lost);

    // R7: a clear with no new event empties the flag
    p_lost_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lost_clr && !trig_pulse |=> !trig_lost);

    // R8: the completion pulse lasts one clock
    p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

endmodule

bind dma_req_handler dma_req_handler_sva #(
    .ARB_W(ARB_W)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_arb_size(cfg_arb_size),
    .trig_pulse  (trig_pulse),
    .lost_clr    (lost_clr),
    .arb_grant   (arb_grant),
    .arb_req     (arb_req),
    .arb_len     (arb_len),
    .done_pulse  (done_pulse),
    .trig_lost   (trig_lost)
);

// File: tb/dma_req_handler_tb.sv
// Directed corner cases plus seeded random stimulus, checked against a
// cycle model written from the requirements.
module dma_req_handler_tb;
    localparam int ARB_W = 4;
    localparam int CNT_W = 10;
    localparam time CLK_PERIOD = 10ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [ARB_W-1:0] cfg_arb_size = 4'd4;
    logic             cfg_burst_only = 1'b0;
    logic             xfer_load = 1'b0;
    logic [CNT_W-1:0] xfer_count = '0;
    logic             fifo_single_req = 1'b0;
    logic             fifo_burst_req = 1'b0;
    logic             trig_pulse = 1'b0;
    logic             lost_clr = 1'b0;
    logic             arb_grant = 1'b0;
    logic             beat_done = 1'b0;
    logic             arb_req;
    logic [ARB_W-1:0] arb_len;
    logic             done_pulse;
    logic             trig_lost;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_req_handler #(.ARB_W(ARB_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_arb_size(cfg_arb_size),
        .cfg_burst_only(cfg_burst_only), .xfer_load(xfer_load),
        .xfer_count(xfer_count), .fifo_single_req(fifo_single_req),
        .fifo_burst_req(fifo_burst_req), .trig_pulse(trig_pulse),
        .lost_clr(lost_clr), .arb_grant(arb_grant), .beat_done(beat_done),
        .arb_req(arb_req), .arb_len(arb_len), .done_pulse(done_pulse),
        .trig_lost(trig_lost)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // Requirement-level model: state 0 idle, 1 request, 2 transfer;
    // source 1 single, 2 block, 3 trigger.
    int m_st, m_src, m_len, m_rem, m_left, m_cnt, m_lost, m_done;
    int t_arbe, t_sel, t_rem, t_left, t_cnt, t_st;
    bit t_beat, t_fin, t_cons, t_drop;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_src = 0; m_len = 0; m_rem = 0;
            m_left = 0; m_cnt = 0; m_lost = 0; m_done = 0;
        end else begin
            t_arbe = (cfg_arb_size == 0) ? 1 : int'(cfg_arb_size);
            t_beat = (m_st == 2) && beat_done;
            t_fin  = t_beat && (m_left == 1);
            t_cons = t_fin && (m_src == 3);
            t_drop = trig_pulse && (m_cnt == 2) && !t_cons;
            t_sel  = (m_cnt != 0) ? 3 : fifo_burst_req ? 2 :
                     (fifo_single_req && !cfg_burst_only) ? 1 : 0;
            t_rem  = xfer_load ? int'(xfer_count) : t_beat ? m_rem - 1 : m_rem;
            t_left = (m_st == 1 && arb_grant) ? m_len : t_beat ? m_left - 1 : m_left;
            t_cnt  = m_cnt + ((trig_pulse && !t_drop) ? 1 : 0) - (t_cons ? 1 : 0);
            t_st   = m_st;
            if (m_st == 0 && m_rem != 0 && t_sel != 0) begin
                t_st  = 1;
                m_src = t_sel;
                m_len = (t_sel == 1) ? 1 : min2(t_arbe, m_rem);
            end else if (m_st == 1 && arb_grant) t_st = 2;
            else if (m_st == 2 && t_fin) t_st = 0;
            m_done = (t_beat && m_rem == 1) ? 1 : 0;
            m_lost = t_drop ? 1 : lost_clr ? 0 : m_lost;
            m_rem = t_rem; m_left = t_left; m_cnt = t_cnt; m_st = t_st;
        end
    end

    // Every-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 arb_req", int'(arb_req), (m_st == 1) ? 1 : 0);
            if (m_st == 1) chk("R4 arb_len", int'(arb_len), m_len);
            chk("R8 done_pulse", int'(done_pulse), m_done);
            chk("R7 trig_lost", int'(trig_lost), m_lost);
        end
    end

    task automatic wait_req(output bit got);
        got = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (arb_req) begin got = 1'b1; break; end
        end
    endtask

    task automatic serve(input int n);
        arb_grant = 1'b1;
        @(negedge clk);
        arb_grant = 1'b0;
        beat_done = 1'b1;
        repeat (n) @(negedge clk);
        beat_done = 1'b0;
    endtask

    task automatic load(input int n);
        xfer_load = 1'b1; xfer_count = CNT_W'(n);
        @(negedge clk);
        xfer_load = 1'b0;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        bit got;
        int svc;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 arb_req", int'(arb_req), 0);
        chk("R10 done_pulse", int'(done_pulse), 0);
        chk("R10 trig_lost", int'(trig_lost), 0);
        rst_n = 1'b1;
        fifo_single_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 no request with zero count", int'(arb_req), 0);

        // R11 + R3: load then single request gives one beat
        load(3);
        wait_req(got);
        chk("R3 single length", int'(arb_len), 1);
        serve(1);
        // R2: block beats single, length min(4, 2)
        fifo_burst_req = 1'b1;
        wait_req(got);
        chk("R2 block over single", int'(arb_len), 2);
        serve(2);
        chk("R8 done after last beat", int'(done_pulse), 1);
        repeat (4) begin
            @(negedge clk);
            chk("R8 no request when empty", int'(arb_req), 0);
        end
        fifo_burst_req = 1'b0; fifo_single_req = 1'b0;

        // R5: block-only mode ignores single requests
        cfg_burst_only = 1'b1;
        load(5);
        fifo_single_req = 1'b1;
        repeat (6) begin
            @(negedge clk);
            chk("R5 single ignored", int'(arb_req), 0);
        end
        fifo_burst_req = 1'b1;
        wait_req(got);
        chk("R4 block length", int'(arb_len), 4);
        serve(4);
        fifo_burst_req = 1'b0; fifo_single_req = 1'b0; cfg_burst_only = 1'b0;

        // R9: stray grant and beat while idle leave the count untouched
        load(3);
        arb_grant = 1'b1; beat_done = 1'b1;
        repeat (3) @(negedge clk);
        arb_grant = 1'b0; beat_done = 1'b0;
        fifo_burst_req = 1'b1;
        wait_req(got);
        chk("R9 count kept", int'(arb_len), 3);
        serve(3);
        fifo_burst_req = 1'b0;

        // R4: size 0 read as 1
        cfg_arb_size = '0;
        load(2);
        fifo_burst_req = 1'b1;
        wait_req(got);
        chk("R4 zero size", int'(arb_len), 1);
        serve(1);
        fifo_burst_req = 1'b0;
        wait_req(got);
        serve(1);
        cfg_arb_size = 4'd2;

        // R6/R7: three back-to-back triggers, two serviced, third dropped
        load(20);
        trig_pulse = 1'b1;
        repeat (3) @(negedge clk);
        trig_pulse = 1'b0;
        chk("R7 third trigger lost", int'(trig_lost), 1);
        svc = 0;
        for (int i = 0; i < 3; i++) begin
            wait_req(got);
            if (got) begin
                svc++;
                chk("R6 trigger length", int'(arb_len), 2);
                serve(2);
            end
        end
        chk("R6 trigger services", svc, 2);
        lost_clr = 1'b1;
        @(negedge clk);
        lost_clr = 1'b0;
        chk("R7 cleared", int'(trig_lost), 0);

        // Random phase
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            fifo_single_req = ($urandom_range(0, 2) != 0);
            fifo_burst_req  = ($urandom_range(0, 3) == 0);
            trig_pulse      = ($urandom_range(0, 5) == 0);
            lost_clr        = ($urandom_range(0, 15) == 0);
            arb_grant       = ($urandom_range(0, 1) == 1);
            beat_done       = ($urandom_range(0, 4) != 0);
            xfer_load       = 1'b0;
            if (m_st == 0) begin
                if (m_rem == 0 && $urandom_range(0, 1) == 1) begin
                    xfer_load  = 1'b1;
                    xfer_count = CNT_W'($urandom_range(1, 40));
                end
                if ($urandom_range(0, 7) == 0) begin
                    cfg_arb_size   = ARB_W'($urandom_range(0, 15));
                    cfg_burst_only = ($urandom_range(0, 2) == 0);
                end
            end
        end
        @(negedge clk);
        summary();
    end
endmodule